// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a two-level translation table held in memory. A request carries the virtual address, the table base value and a flag that says whether tiny pages are allowed. The walker fetches the first-level descriptor through a single-word memory read port. It decodes the descriptor and, when the descriptor points at a second-level table, fetches one more word before it reports the result.

A finished walk is announced with a one-cycle `done` pulse. Alongside the pulse the block presents the physical address, a page type code, the cacheable/bufferable pair, the 4-bit domain and the permission field, or a fault flag with every result field cleared. Only one walk runs at a time. The memory side may take any number of cycles to answer each read.

Top module: `pt_walker`

## Requirements
- R1: The first read of every walk is at address {base[31:14], va[31:20], 2'b00}.
- R2: First-level descriptor bits 1:0 pick the kind: 00 fault, 01 coarse table, 10 section, 11 fine table. When `tiny_en` is 0, kind 11 is treated as a fault. A first-level fault ends the walk after one read.
- R3: A section ends the walk after one read with pa = {d[31:20], va[19:0]}, cb = d[3:2], ap = {6'b0, d[11:10]} and page type 0.
- R4: For a coarse table the second read is at {d1[31:10], va[19:12], 2'b00}.
- R5: For a fine table the second read is at {d1[31:12], va[19:10], 2'b00}.
- R6: A second-level descriptor with bits 1:0 = 00 gives a fault. Otherwise cb is that descriptor's bits 3:2.
- R7: Second-level kind 01 is a large page: pa = {d2[31:16], va[15:0]}, ap = d2[11:4], page type 1.
- R8: Second-level kind 10 is a small page: pa = {d2[31:12], va[11:0]}, ap = d2[11:4], page type 2.
- R9: Second-level kind 11 is a tiny page: pa = {d2[31:10], va[9:0]}, ap = {6'b0, d2[5:4]}, page type 3.
- R10: For every result without a fault, domain is bits 8:5 of the first-level descriptor.
- R11: `req_ready` is high only when idle. A request offered while a walk runs is ignored. `done` lasts one cycle. On a fault, pa, type, cb, domain and ap are all zero.
- R12: Each read is a one-cycle `mem_req` pulse. The walker then waits, issuing nothing and finishing nothing, until `mem_rvalid` arrives.
- R13: A synchronous reset returns the walker to idle with all outputs zero and drops any walk in progress. A read response that arrives after the reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request accepted on this cycle |
| req_va | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | Table base value (bits 31:14 used) |
| tiny_en | input | 1 | Tiny pages supported |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read address, word aligned |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data (descriptor) |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Translation fault |
| pa | output | 32 | Physical address |
| ptype | output | 2 | 0 section, 1 large, 2 small, 3 tiny |
| cb | output | 2 | Cacheable/bufferable bits |
| domain | output | 4 | Domain number |
| ap | output | 8 | Access permission field |

## Verification
A walker stuck in the wrong state shows at the ports within one read. A missing or extra `mem_req` changes the read count, and a response applied to the wrong level produces the wrong second address or a wrong splice in `pa`. A wrong held domain or table address appears in the `done` cycle of the same walk. A stale state after reset shows as `req_ready` low, or as a spurious `done` once a stray response arrives. Varying the response latency and offering requests during a walk expose handshake errors within a few cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned AW    = 32;
  localparam int unsigned DW    = 32;
  localparam int unsigned DOM_W = 4;
  localparam int unsigned AP_W  = 8;
  localparam int unsigned CB_W  = 2;

  typedef logic [AW-1:0] addr_t;
  typedef logic [DW-1:0] desc_t;

  typedef enum logic [1:0] {
    L1_FAULT   = 2'b00,
    L1_COARSE  = 2'b01,
    L1_SECTION = 2'b10,
    L1_FINE    = 2'b11
  } l1_kind_e;

  typedef enum logic [1:0] {
    PG_SECTION = 2'd0,
    PG_LARGE   = 2'd1,
    PG_SMALL   = 2'd2,
    PG_TINY    = 2'd3
  } page_e;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_ISSUE, S_L1_WAIT, S_L2_ISSUE, S_L2_WAIT
  } walk_st_e;

  typedef struct packed {
    logic            fault;
    addr_t           pa;
    page_e           ptype;
    logic [CB_W-1:0] cb;
    logic [AP_W-1:0] ap;
  } xlat_t;

  function automatic addr_t l1_fetch_addr(addr_t base, addr_t va);
    return {base[31:14], va[31:20], 2'b00};
  endfunction

  function automatic addr_t coarse_fetch_addr(desc_t d, addr_t va);
    return {d[31:10], va[19:12], 2'b00};
  endfunction

  function automatic addr_t fine_fetch_addr(desc_t d, addr_t va);
    return {d[31:12], va[19:10], 2'b00};
  endfunction

  function automatic xlat_t section_result(desc_t d, addr_t va);
    xlat_t r;
    r.fault = 1'b0;
    r.pa    = {d[31:20], va[19:0]};
    r.ptype = PG_SECTION;
    r.cb    = d[3:2];
    r.ap    = {6'b0, d[11:10]};
    return r;
  endfunction

  function automatic xlat_t page_result(desc_t d, addr_t va);
    xlat_t r;
    r = '0;
    r.cb = d[3:2];
    case (d[1:0])
      2'b01: begin r.ptype = PG_LARGE; r.pa = {d[31:16], va[15:0]}; r.ap = d[11:4]; end
      2'b10: begin r.ptype = PG_SMALL; r.pa = {d[31:12], va[11:0]}; r.ap = d[11:4]; end
      2'b11: begin r.ptype = PG_TINY;  r.pa = {d[31:10], va[9:0]};  r.ap = {6'b0, d[5:4]}; end
      default: r = '{fault: 1'b1, pa: '0, ptype: PG_SECTION, cb: '0, ap: '0};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
  import ptw_pkg::*;
(
  input  desc_t             desc,
  input  addr_t             va,
  input  logic              tiny_ok,
  output l1_kind_e          kind,
  output addr_t             next_addr,
  output xlat_t             sect,
  output logic [DOM_W-1:0]  dom
);
  l1_kind_e raw_kind;

  always_comb begin
    raw_kind  = l1_kind_e'(desc[1:0]);
    kind      = (raw_kind == L1_FINE && !tiny_ok) ? L1_FAULT : raw_kind;
    next_addr = (raw_kind == L1_FINE) ? fine_fetch_addr(desc, va)
                                      : coarse_fetch_addr(desc, va);
    sect      = section_result(desc, va);
    dom       = desc[8:5];
  end
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
(
  input  desc_t desc,
  input  addr_t va,
  output xlat_t res
);
  always_comb res = page_result(desc, va);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic [31:0] tbl_base,
  input  logic        tiny_en,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic        fault,
  output logic [31:0] pa,
  output logic [1:0]  ptype,
  output logic [1:0]  cb,
  output logic [3:0]  domain,
  output logic [7:0]  ap
);
  walk_st_e         st;
  addr_t            va_q, base_q, l2_addr_q;
  logic             tiny_q;
  logic [DOM_W-1:0] dom_q;

  // named internal events
  logic     walk_start, l1_rsp, l2_rsp, waiting;
  l1_kind_e l1_kind;
  addr_t    l1_next;
  xlat_t    l1_sect, l2_res;
  logic [DOM_W-1:0] l1_dom;

  assign walk_start = req_valid && req_ready;
  assign l1_rsp     = (st == S_L1_WAIT) && mem_rvalid;
  assign l2_rsp     = (st == S_L2_WAIT) && mem_rvalid;
  assign waiting    = (st == S_L1_WAIT) || (st == S_L2_WAIT);
  assign req_ready  = (st == S_IDLE);
  assign mem_req    = (st == S_L1_ISSUE) || (st == S_L2_ISSUE);
  assign mem_addr   = (st == S_L2_ISSUE) ? l2_addr_q : l1_fetch_addr(base_q, va_q);

  ptw_l1_decode u_l1 (
    .desc(mem_rdata), .va(va_q), .tiny_ok(tiny_q),
    .kind(l1_kind), .next_addr(l1_next), .sect(l1_sect), .dom(l1_dom)
  );

  ptw_l2_decode u_l2 (.desc(mem_rdata), .va(va_q), .res(l2_res));

  task automatic finish(input xlat_t r, input logic [DOM_W-1:0] d);
    done   <= 1'b1;
    fault  <= r.fault;
    pa     <= r.fault ? '0 : r.pa;
    ptype  <= r.fault ? 2'd0 : r.ptype;
    cb     <= r.fault ? '0 : r.cb;
    ap     <= r.fault ? '0 : r.ap;
    domain <= r.fault ? '0 : d;
    st     <= S_IDLE;
  endtask

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      va_q      <= '0;
      base_q    <= '0;
      tiny_q    <= 1'b0;
      l2_addr_q <= '0;
      dom_q     <= '0;
      done      <= 1'b0;
      fault     <= 1'b0;
      pa        <= '0;
      ptype     <= '0;
      cb        <= '0;
      domain    <= '0;
      ap        <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (walk_start) begin
          va_q   <= req_va;
          base_q <= tbl_base;
          tiny_q <= tiny_en;
          st     <= S_L1_ISSUE;
        end
        S_L1_ISSUE: st <= S_L1_WAIT;
        S_L1_WAIT: if (l1_rsp) begin
          case (l1_kind)
            L1_FAULT:   finish('{fault: 1'b1, pa: '0, ptype: PG_SECTION, cb: '0, ap: '0}, '0);
            L1_SECTION: finish(l1_sect, l1_dom);
            default: begin
              l2_addr_q <= l1_next;
              dom_q     <= l1_dom;
              st        <= S_L2_ISSUE;
            end
          endcase
        end
        S_L2_ISSUE: st <= S_L2_WAIT;
        S_L2_WAIT: if (l2_rsp) finish(l2_res, dom_q);
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) mem_req |=> !mem_req); // R12
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst) (waiting && !mem_rvalid) |=> (!done && !mem_req)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R11
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst) walk_start |=> !req_ready); // R11
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (rst) (done && fault) |-> (pa == '0 && ap == '0 && cb == '0 && domain == '0)); // R11
  AST_SECTION_ONE_READ: assert property (@(posedge clk) disable iff (rst) (l1_rsp && l1_kind == L1_SECTION) |=> (done && !fault)); // R3
  AST_NO_TINY_FINE: assert property (@(posedge clk) disable iff (rst) (l1_rsp && !tiny_q && mem_rdata[1:0] == 2'b11) |=> (done && fault)); // R2
  AST_TINY_AP_NARROW: assert property (@(posedge clk) disable iff (rst) (done && !fault && ptype == 2'd3) |-> ap[7:2] == 6'd0); // R9
endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [31:0] tbl_base = '0;
  logic        tiny_en = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, fault;
  logic [31:0] pa;
  logic [1:0]  ptype, cb;
  logic [3:0]  domain;
  logic [7:0]  ap;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .tbl_base(tbl_base), .tiny_en(tiny_en),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .done(done), .fault(fault), .pa(pa),
    .ptype(ptype), .cb(cb), .domain(domain), .ap(ap)
  );

  localparam int NV = 8;
  // columns: va, base, tiny, desc1, desc2, reads, second address, fault, type, pa, cb, domain, ap
  localparam logic [31:0] V_VA [NV] = '{32'h12345678, 32'h00423ABC, 32'h00F12345, 32'h00512F0F,
                                        32'h80000000, 32'h00512F0F, 32'h00423ABC, 32'h00512F0F};
  localparam logic [31:0] V_BASE [NV] = '{32'h00008000, 32'h00100000, 32'h00100000, 32'h00004000,
                                          32'h00000000, 32'h00004000, 32'h00100000, 32'h00004000};
  localparam logic V_TINY [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [31:0] V_D1 [NV] = '{32'hABC00CAE, 32'h002005E1, 32'h00300041, 32'h00601123,
                                        32'hFFFFFFFC, 32'h00601123, 32'h002005E1, 32'h00601123};
  localparam logic [31:0] V_D2 [NV] = '{32'h0, 32'h77777A56, 32'hBEEF03C9, 32'hCAFE17EF,
                                        32'h0, 32'h0, 32'hFFFFFFF0, 32'h12345152};
  localparam int V_RD [NV] = '{1, 2, 2, 2, 1, 1, 2, 2};
  localparam logic [31:0] V_L2A [NV] = '{32'h0, 32'h0020048C, 32'h00300048, 32'h0060112C,
                                         32'h0, 32'h0, 32'h0020048C, 32'h0060112C};
  localparam logic V_FLT [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic [1:0] V_TYP [NV] = '{2'd0, 2'd2, 2'd1, 2'd3, 2'd0, 2'd0, 2'd0, 2'd2};
  localparam logic [31:0] V_PA [NV] = '{32'hABC45678, 32'h77777ABC, 32'hBEEF2345, 32'hCAFE170F,
                                        32'h0, 32'h0, 32'h0, 32'h12345F0F};
  localparam logic [1:0] V_CB [NV] = '{2'd3, 2'd1, 2'd2, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0};
  localparam logic [3:0] V_DOM [NV] = '{4'd5, 4'd15, 4'd2, 4'd9, 4'd0, 4'd0, 4'd0, 4'd9};
  localparam logic [7:0] V_AP [NV] = '{8'h03, 8'hA5, 8'h3C, 8'h02, 8'h00, 8'h00, 8'h00, 8'h15};

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string pa_req(input int i);
    if (V_FLT[i]) return (V_RD[i] == 1) ? "R2" : "R6";
    case (V_TYP[i])
      2'd0: return "R3";
      2'd1: return "R7";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic run_vec(input int i, input int lat, input bit hammer);
    int reads = 0;
    int guard = 0;
    bit fin = 0;
    @(negedge clk);
    req_valid = 1'b1; req_va = V_VA[i]; tbl_base = V_BASE[i]; tiny_en = V_TINY[i];
    chk("R11", "ready when idle", 32'(req_ready), 32'd1);
    @(negedge clk);
    if (hammer) req_va = ~V_VA[i]; else req_valid = 1'b0;
    while (!fin && guard < 300) begin
      if (done) begin
        fin = 1;
        req_valid = 1'b0;
        chk("R12", "read count", 32'(reads), 32'(V_RD[i]));
        chk(pa_req(i), "fault", 32'(fault), 32'(V_FLT[i]));
        chk(pa_req(i), "pa", pa, V_PA[i]);
        chk(pa_req(i), "type", 32'(ptype), 32'(V_TYP[i]));
        chk(V_FLT[i] ? "R11" : "R6", "cb", 32'(cb), 32'(V_CB[i]));
        chk(V_FLT[i] ? "R11" : "R10", "domain", 32'(domain), 32'(V_DOM[i]));
        chk(pa_req(i), "ap", 32'(ap), 32'(V_AP[i]));
      end else if (mem_req) begin
        chk("R11", "busy during walk", 32'(req_ready), 32'd0);
        if (reads == 0)
          chk("R1", "first address", mem_addr,
              (V_BASE[i] & 32'hFFFFC000) | ((V_VA[i] >> 18) & 32'h00003FFC));
        else
          chk(V_TINY[i] && V_D1[i][1:0] == 2'b11 ? "R5" : "R4", "second address", mem_addr, V_L2A[i]);
        reads++;
        repeat (lat + 1) begin
          @(negedge clk);
          if (done || mem_req) chk("R12", "quiet while waiting", 32'(done | mem_req), 32'd0);
        end
        mem_rvalid = 1'b1;
        mem_rdata = (reads == 1) ? V_D1[i] : V_D2[i];
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata = '0;
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    if (!fin) chk("R12", "walk finished", 32'd0, 32'd1);
    @(negedge clk);
    chk("R11", "done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R13", "ready in reset", 32'(req_ready), 32'd1);
    chk("R13", "no request in reset", 32'(mem_req), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R13", "outputs clear", {pa[29:0], done, fault}, 32'd0);

    // table-driven walks
    for (int i = 0; i < NV; i++) run_vec(i, i % 4, i[0]);
    // same entries again with other latencies
    for (int i = 0; i < NV; i++) run_vec(i, (i * 3 + 5) % 7, !i[0]);

    // reset during a walk drops it; a late response does nothing (R13)
    @(negedge clk);
    req_valid = 1'b1; req_va = V_VA[1]; tbl_base = V_BASE[1]; tiny_en = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    while (!mem_req) @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R13", "idle after reset", 32'(req_ready), 32'd1);
    chk("R13", "pa cleared", pa, 32'd0);
    chk("R13", "domain cleared", 32'(domain), 32'd0);
    mem_rvalid = 1'b1; mem_rdata = V_D1[0];
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = '0;
    for (int k = 0; k < 4; k++) begin
      chk("R13", "stray response ignored", 32'({done, mem_req}), 32'd0);
      @(negedge clk);
    end
    run_vec(3, 2, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL R12 watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule